// File: doc/BRIEF.md
# Peripheral Pin-Select Crossbar

This block routes internal peripheral signals to and from a bank of remappable package pins. Every peripheral input owns a select register that names the pin feeding it. Every pin owns a select register that names the peripheral output driving it, or none. The block holds both register banks and builds the input multiplexers and the output multiplexers from them. It also generates the output-enable for each pin.

A separate lock controller decides when configuration may change, and reports that on `cfg_open`. A bus write presented while `cfg_open` is low is accepted but has no effect. No mapping blocks any other mapping. One pin may feed many peripheral inputs. One peripheral output may appear on many pins at once.

After reset every register reads zero. In that state every peripheral input listens to pin 0, and every pin is released to its GPIO owner.

Top module: `pps_xbar`

## Requirements
- R1: After reset every select register reads back 0x0000 on `rd_data`. Address bit 3 picks the bank (0 = input selects, 1 = pin output selects) and bits 2:0 pick the register. Input indices at or above NUM_IN read 0.
- R2: With all registers at reset value, every bit of `periph_in` equals `pin_in[0]`.
- R3: With all registers at reset value, `pin_oe` and `pin_out` are all zero whatever `periph_out` carries.
- R4: An input select value v below NUM_PINS makes `periph_in[j]` equal `pin_in[v]` in the same cycle, with no register on the path.
- R5: An input select value at or above NUM_PINS holds `periph_in[j]` at 0.
- R6: Several input select registers may name the same pin, and each of those inputs follows that pin.
- R7: A pin select code k from 1 to NUM_OUT sets `pin_oe` for that pin and drives `periph_out[k-1]` onto `pin_out`.
- R8: A pin select code of 0, or any code above NUM_OUT, clears that pin's `pin_oe` and holds its `pin_out` at 0.
- R9: Several pins may carry the same code, and each of those pins then drives the same peripheral output.
- R10: A write with `cfg_open` low leaves every register unchanged. A write with `cfg_open` high lands on the following clock edge.
- R11: A write changes only the addressed register. No combination of values is refused or altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address: bank bit at the top, register index below |
| bus_wdata | input | DATA_W | Write data |
| cfg_open | input | 1 | Write permission from the lock controller |
| rd_addr | input | ADDR_W | Readback address, same map as writes |
| rd_data | output | DATA_W | Combinational readback of the addressed register |
| pin_in | input | NUM_PINS | Values seen on the remappable pins |
| periph_out | input | NUM_OUT | Outputs of the peripherals |
| periph_in | output | NUM_IN | Routed inputs to the peripherals |
| pin_out | output | NUM_PINS | Routed values toward the pins |
| pin_oe | output | NUM_PINS | Per-pin output enable |

## Verification
The assertions assume that `bus_we`, `cfg_open` and the addresses are settled at each rising edge. They also assume that reset is asserted from time zero, so the first sampled state is the cleared register file. The bench changes every input shortly after a rising edge and compares outputs on the falling edge, so the combinational paths have settled when they are checked. Select codes are aimed at the edges of each range: pin 0, the last pin, one past it, all ones, output code 0, code NUM_OUT, and code NUM_OUT+1.

// File: rtl/pps_xbar.sv
module pps_xbar #(
  parameter int NUM_PINS = 8,
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 6,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_PINS > NUM_IN ? NUM_PINS : NUM_IN),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                cfg_open,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_OUT-1:0]  periph_out,
  output logic [NUM_IN-1:0]   periph_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic [NUM_IN-1:0][DATA_W-1:0]   in_sel;
  logic [NUM_PINS-1:0][DATA_W-1:0] out_sel;

  wire             wr_bank = bus_addr[ADDR_W-1];
  wire [IDX_W-1:0] wr_idx  = bus_addr[IDX_W-1:0];
  wire             rd_bank = rd_addr[ADDR_W-1];
  wire [IDX_W-1:0] rd_idx  = rd_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sel  <= '0;
      out_sel <= '0;
    end else if (bus_we && cfg_open) begin
      for (int k = 0; k < NUM_IN; k++)
        if (!wr_bank && wr_idx == IDX_W'(k)) in_sel[k] <= bus_wdata;
      for (int k = 0; k < NUM_PINS; k++)
        if (wr_bank && wr_idx == IDX_W'(k)) out_sel[k] <= bus_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_IN; k++)
      if (!rd_bank && rd_idx == IDX_W'(k)) rd_data = in_sel[k];
    for (int k = 0; k < NUM_PINS; k++)
      if (rd_bank && rd_idx == IDX_W'(k)) rd_data = out_sel[k];
  end

  always_comb begin
    periph_in = '0;
    for (int j = 0; j < NUM_IN; j++)
      for (int p = 0; p < NUM_PINS; p++)
        if (in_sel[j] == DATA_W'(p)) periph_in[j] = pin_in[p];
  end

  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    for (int i = 0; i < NUM_PINS; i++)
      for (int f = 0; f < NUM_OUT; f++)
        if (out_sel[i] == DATA_W'(f + 1)) begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = periph_out[f];
        end
  end

endmodule

module pps_xbar_chk #(
  parameter int NUM_PINS = 8,
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 6,
  parameter int DATA_W   = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_we,
  input logic                            cfg_open,
  input logic [NUM_IN-1:0][DATA_W-1:0]   in_sel,
  input logic [NUM_PINS-1:0][DATA_W-1:0] out_sel,
  input logic [NUM_PINS-1:0]             pin_in,
  input logic [NUM_IN-1:0]               periph_in,
  input logic [NUM_PINS-1:0]             pin_out,
  input logic [NUM_PINS-1:0]             pin_oe
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_sel == '0 && out_sel == '0));

  // R10
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && cfg_open) |=> ($stable(in_sel) && $stable(out_sel)));

  // R8
  quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  for (genvar j = 0; j < NUM_IN; j++) begin : g_in
    // R5
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel[j] >= DATA_W'(NUM_PINS)) |-> !periph_in[j]);
    // R4
    in_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel[j] < DATA_W'(NUM_PINS)) |->
        (periph_in[j] == |(pin_in & (NUM_PINS'(1) << in_sel[j]))));
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R7
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel[i] != '0 && out_sel[i] <= DATA_W'(NUM_OUT)) |-> pin_oe[i]);
    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel[i] == '0 || out_sel[i] > DATA_W'(NUM_OUT)) |-> !pin_oe[i]);
  end

endmodule

bind pps_xbar pps_xbar_chk #(
  .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cfg_open(cfg_open),
  .in_sel(in_sel), .out_sel(out_sel), .pin_in(pin_in),
  .periph_in(periph_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pps_xbar_tb.sv
module pps_xbar_tb;
  localparam int NP = 8, NI = 4, NO = 6, DW = 16, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, cfg_open = 1'b0;
  logic [AW-1:0] bus_addr = '0, rd_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NO-1:0] periph_out = '0;
  logic [NI-1:0] periph_in;

  always #2.5 clk = ~clk;

  pps_xbar #(.NUM_PINS(NP), .NUM_IN(NI), .NUM_OUT(NO), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg_open(cfg_open), .rd_addr(rd_addr),
    .rd_data(rd_data), .pin_in(pin_in), .periph_out(periph_out),
    .periph_in(periph_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct { string req; int sig; logic [DW-1:0] exp; } item_t;
  item_t sb[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = sb.pop_front();
      case (it.sig)
        0: act = rd_data;
        1: act = DW'(periph_in);
        2: act = DW'(pin_out);
        default: act = DW'(pin_oe);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic open);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; cfg_open = open;
    step();
    bus_we = 1'b0; cfg_open = 1'b0;
  endtask

  task automatic expect_(input string r, input int s, input logic [DW-1:0] e);
    sb.push_back('{req: r, sig: s, exp: e});
  endtask

  task automatic rd_chk(input string r, input logic [AW-1:0] a, input logic [DW-1:0] e);
    rd_addr = a; expect_(r, 0, e); step();
  endtask

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset readback
    rd_chk("R1", 4'h0, 16'h0); rd_chk("R1", 4'h3, 16'h0);
    rd_chk("R1", 4'h8, 16'h0); rd_chk("R1", 4'hF, 16'h0);
    rd_chk("R1", 4'h4, 16'h0);
    // R2 inputs follow pin 0
    pin_in = 8'h01; expect_("R2", 1, 16'hF); step();
    pin_in = 8'hFE; expect_("R2", 1, 16'h0); step();
    // R3 pins released
    periph_out = 6'h3F; expect_("R3", 2, 16'h0); expect_("R3", 3, 16'h0); step();
    // R4 route pin 5 to input 1, same-cycle response
    wr(4'h1, 16'd5, 1'b1);
    pin_in = 8'h20; expect_("R4", 1, 16'h2); step();
    pin_in = 8'h21; expect_("R4", 1, 16'hF); step();
    // R5 out-of-range input codes
    wr(4'h2, 16'd8, 1'b1);
    pin_in = 8'hFF; expect_("R5", 1, 16'hB); step();
    wr(4'h3, 16'hFFFF, 1'b1);
    expect_("R5", 1, 16'h3); step();
    // R6 one pin fans out to several inputs
    wr(4'h0, 16'd5, 1'b1); wr(4'h3, 16'd5, 1'b1);
    pin_in = 8'h20; expect_("R6", 1, 16'hB); step();
    pin_in = 8'hDF; expect_("R6", 1, 16'h0); step();
    // R7 pin 2 carries peripheral output 2
    wr(4'hA, 16'd3, 1'b1);
    periph_out = 6'h04; expect_("R7", 2, 16'h04); expect_("R7", 3, 16'h04); step();
    periph_out = 6'h3B; expect_("R7", 2, 16'h00); expect_("R7", 3, 16'h04); step();
    // R9 same output on pins 2 and 6
    wr(4'hE, 16'd3, 1'b1);
    periph_out = 6'h04; expect_("R9", 2, 16'h44); expect_("R9", 3, 16'h44); step();
    // R8 code NUM_OUT+1 leaves pin 7 released
    wr(4'hF, 16'd7, 1'b1);
    periph_out = 6'h3F; expect_("R8", 2, 16'h44); expect_("R8", 3, 16'h44); step();
    // R7 highest valid code on pin 7
    wr(4'hF, 16'd6, 1'b1);
    periph_out = 6'h20; expect_("R7", 2, 16'h80); expect_("R7", 3, 16'hC4); step();
    // R8 code zero releases pin 7 again
    wr(4'hF, 16'd0, 1'b1);
    periph_out = 6'h3F; expect_("R8", 2, 16'h44); expect_("R8", 3, 16'h44); step();
    // R10 locked writes ignored
    wr(4'hA, 16'd1, 1'b0); wr(4'h0, 16'd0, 1'b0);
    rd_chk("R10", 4'hA, 16'd3); rd_chk("R10", 4'h0, 16'd5);
    pin_in = 8'h20; expect_("R10", 1, 16'hB); expect_("R10", 3, 16'h44); step();
    wr(4'h0, 16'd0, 1'b1);
    rd_chk("R10", 4'h0, 16'd0);
    // R11 every register holds its own value
    rd_chk("R11", 4'h1, 16'd5); rd_chk("R11", 4'h2, 16'd8);
    rd_chk("R11", 4'h3, 16'd5); rd_chk("R11", 4'hA, 16'd3);
    rd_chk("R11", 4'hE, 16'd3); rd_chk("R11", 4'hF, 16'd0);
    rd_chk("R11", 4'h9, 16'd0);
    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule